// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block keeps a small direct-mapped private cache coherent with its peers on a single shared bus. Each line holds a tag, one data word and a two-bit coherence state: Invalid, Shared (clean, possibly held elsewhere), Exclusive (clean, held only here) or Modified (dirty, held only here). The controller serves one processor read or write at a time. It requests the bus to fetch lines, announce ownership or write dirty data back, and it watches the other caches' bus traffic through a snoop port.

A fill becomes Exclusive when no peer reports holding the address, so a later write to it stays local. A write to a Shared line must first win the bus and broadcast an invalidate. When a snooped read or read-for-ownership hits a dirty line, the controller aborts that transaction and writes the line back ahead of any bus work of its own. It then downgrades or drops the line so that the requester's retry finds memory up to date. Bus arbitration and main memory are outside the block.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_ready_o` and `bus_req_o` are low, and a snoop to any address sees `snp_shared_o` low.
- R2: A read miss requests the bus with command RD (code 1) at the processor address and returns `bus_rdata_i`. The line becomes Shared if `bus_shared_i` was high at the grant, otherwise Exclusive.
- R3: A read hit returns the stored word with `cpu_ready_o` high in the cycle after acceptance and no bus request.
- R4: A write hit on an Exclusive or Modified line completes in the cycle after acceptance with no bus request, and leaves the line Modified.
- R5: A write hit on a Shared line issues command INV (code 3) at the processor address, then completes with the line Modified.
- R6: A write miss issues command RWITM (code 2) and installs the processor data with the line Modified.
- R7: `snp_shared_o` is high, in the same cycle and for any snoop command, exactly when a valid line matches `snp_addr_i`.
- R8: A snooped RD (code 1) leaves a Shared line unchanged and moves an Exclusive line to Shared.
- R9: A snooped RD or RWITM that hits a Modified line raises `snp_abort_o` in the same cycle. On the next cycle the block requests command WB (code 4) carrying the line's address and data. After that writeback the line is Shared for RD and Invalid for RWITM.
- R10: A snooped RWITM or INV that hits a Shared or Exclusive line makes it Invalid, so the next access misses.
- R11: If a Shared line awaiting the grant for its INV is invalidated by a peer, the write is reissued as an RWITM miss.
- R12: A grant of RD or RWITM with `bus_abort_i` high does not complete. The same command is requested again.
- R13: A miss whose victim is Modified first writes the victim back with WB at the victim address, then fetches. A clean victim is dropped with no writeback.
- R14: A pending snoop writeback takes the bus before a processor fill that is already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address (tag above index) |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Grant; the transaction completes at this edge |
| bus_cmd_o | output | 3 | 1 RD, 2 RWITM, 3 INV, 4 WB |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Writeback data |
| bus_rdata_i | input | DATA_W | Fill data from memory |
| bus_shared_i | input | 1 | A peer holds the fetched address |
| bus_abort_i | input | 1 | A peer aborted this transaction |
| snp_valid_i | input | 1 | Peer transaction visible on the bus |
| snp_cmd_i | input | 3 | Peer command, same codes |
| snp_addr_i | input | ADDR_W | Peer address |
| snp_shared_o | output | 1 | This cache holds the snooped address |
| snp_abort_o | output | 1 | Abort peer transaction (dirty hit) |

## Verification
The assertions assume that a grant only arrives while the block requests the bus, and that a snoop never shares a cycle with this block's own grant, because one bus carries one transaction. They also assume that the processor holds its request fields steady until ready. The bench arbiter grants only a pending request, one cycle after it appears, and drops the grant after one edge. Snoops are injected only while the bus is idle or while the arbiter deliberately withholds the grant, which is how the race and priority cases are staged.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHD = 2'b01,
    ST_EXC = 2'b10,
    ST_MOD = 2'b11
  } line_st_e;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_RD    = 3'd1,
    CMD_RWITM = 3'd2,
    CMD_INV   = 3'd3,
    CMD_WB    = 3'd4
  } bus_cmd_e;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [1:0]        upd_st_i,
  input  logic              upd_fill_i,
  input  logic [TAG_W-1:0]  upd_tag_i,
  input  logic [DATA_W-1:0] upd_data_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic [1:0]        ra_st_o,
  output logic [TAG_W-1:0]  ra_tag_o,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic [1:0]        rb_st_o,
  output logic [TAG_W-1:0]  rb_tag_o,
  output logic [DATA_W-1:0] rb_data_o
);
  localparam int LINES = 1 << IDX_W;

  logic [1:0]        st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_INV;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (upd_i) begin
      st_q[upd_idx_i] <= upd_st_i;
      if (upd_fill_i) begin
        tag_q[upd_idx_i]  <= upd_tag_i;
        data_q[upd_idx_i] <= upd_data_i;
      end
    end
  end

  assign ra_st_o   = st_q[ra_idx_i];
  assign ra_tag_o  = tag_q[ra_idx_i];
  assign ra_data_o = data_q[ra_idx_i];
  assign rb_st_o   = st_q[rb_idx_i];
  assign rb_tag_o  = tag_q[rb_idx_i];
  assign rb_data_o = data_q[rb_idx_i];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             valid_i,
  input  logic [2:0]       cmd_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [1:0]       line_st_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             shared_o,
  output logic             abort_o,
  output logic             upd_o,
  output logic [1:0]       upd_st_o,
  output logic [1:0]       wb_st_o
);
  logic hit, is_rd, is_own;

  assign hit    = valid_i && (line_st_i != ST_INV) && (line_tag_i == tag_i);
  assign is_rd  = (cmd_i == CMD_RD);
  assign is_own = (cmd_i == CMD_RWITM) || (cmd_i == CMD_INV);

  assign shared_o = hit;
  assign abort_o  = hit && (line_st_i == ST_MOD) && (is_rd || cmd_i == CMD_RWITM);
  // dirty hits are resolved after the writeback, not here
  assign wb_st_o  = is_rd ? ST_SHD : ST_INV;

  always_comb begin
    upd_o    = 1'b0;
    upd_st_o = line_st_i;
    if (hit && line_st_i != ST_MOD) begin
      if (is_rd && line_st_i == ST_EXC) begin
        upd_o    = 1'b1;
        upd_st_o = ST_SHD;
      end else if (is_own) begin
        upd_o    = 1'b1;
        upd_st_o = ST_INV;
      end
    end
  end
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              bus_abort_i,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_abort_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_UPG, F_EVICT, F_FILL} fsm_e;

  fsm_e fsm_q, fsm_d;
  logic              ready_q, ready_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  logic [1:0]        ca_st, sb_st;
  logic [TAG_W-1:0]  ca_tag, sb_tag;
  logic [DATA_W-1:0] ca_data, sb_data;
  logic              cpu_hit, cpu_excl, accept, fsm_gnt;

  logic              snp_upd;
  logic [1:0]        snp_upd_st, snp_wb_st;

  logic              wb_pend_q;
  logic [IDX_W-1:0]  wb_idx_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;
  logic [1:0]        wb_next_q;

  logic              upd;
  logic [IDX_W-1:0]  upd_idx;
  logic [1:0]        upd_st;
  logic              upd_fill;
  logic [DATA_W-1:0] upd_data;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  mesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk_i, .rst_ni,
    .upd_i(upd), .upd_idx_i(upd_idx), .upd_st_i(upd_st), .upd_fill_i(upd_fill),
    .upd_tag_i(cpu_tag), .upd_data_i(upd_data),
    .ra_idx_i(cpu_idx), .ra_st_o(ca_st), .ra_tag_o(ca_tag), .ra_data_o(ca_data),
    .rb_idx_i(snp_idx), .rb_st_o(sb_st), .rb_tag_o(sb_tag), .rb_data_o(sb_data)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .valid_i(snp_valid_i), .cmd_i(snp_cmd_i), .tag_i(snp_tag),
    .line_st_i(sb_st), .line_tag_i(sb_tag),
    .shared_o(snp_shared_o), .abort_o(snp_abort_o),
    .upd_o(snp_upd), .upd_st_o(snp_upd_st), .wb_st_o(snp_wb_st)
  );

  assign cpu_hit  = (ca_st != ST_INV) && (ca_tag == cpu_tag);
  assign cpu_excl = (ca_st == ST_EXC) || (ca_st == ST_MOD);
  assign accept   = cpu_req_i && !ready_q && !wb_pend_q && !snp_valid_i;
  // snoop writeback owns the bus while pending
  assign fsm_gnt  = bus_gnt_i && !wb_pend_q;

  always_comb begin
    bus_req_o   = 1'b0;
    bus_cmd_o   = CMD_NONE;
    bus_addr_o  = cpu_addr_i;
    bus_wdata_o = ca_data;
    case (fsm_q)
      F_UPG: begin
        bus_req_o = cpu_hit;
        bus_cmd_o = CMD_INV;
      end
      F_EVICT: begin
        bus_req_o  = 1'b1;
        bus_cmd_o  = CMD_WB;
        bus_addr_o = {ca_tag, cpu_idx};
      end
      F_FILL: begin
        bus_req_o = 1'b1;
        bus_cmd_o = cpu_we_i ? CMD_RWITM : CMD_RD;
      end
      default: ;
    endcase
    if (wb_pend_q) begin
      bus_req_o   = 1'b1;
      bus_cmd_o   = CMD_WB;
      bus_addr_o  = wb_addr_q;
      bus_wdata_o = wb_data_q;
    end
  end

  always_comb begin
    fsm_d   = fsm_q;
    ready_d = 1'b0;
    rdata_d = rdata_q;
    case (fsm_q)
      F_IDLE: if (accept) begin
        if (cpu_hit) begin
          if (!cpu_we_i) begin
            ready_d = 1'b1;
            rdata_d = ca_data;
          end else if (cpu_excl) ready_d = 1'b1;
          else fsm_d = F_UPG;
        end else if (ca_st == ST_MOD) fsm_d = F_EVICT;
        else fsm_d = F_FILL;
      end
      F_UPG: begin
        if (!cpu_hit) fsm_d = F_FILL;  // lost the race: reissue as miss
        else if (fsm_gnt) begin
          fsm_d   = F_IDLE;
          ready_d = 1'b1;
        end
      end
      F_EVICT: if (fsm_gnt) fsm_d = F_FILL;
      F_FILL: if (fsm_gnt && !bus_abort_i) begin
        fsm_d   = F_IDLE;
        ready_d = 1'b1;
        rdata_d = cpu_we_i ? cpu_wdata_i : bus_rdata_i;
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_comb begin
    upd      = 1'b0;
    upd_idx  = cpu_idx;
    upd_st   = ST_INV;
    upd_fill = 1'b0;
    upd_data = cpu_wdata_i;
    if (wb_pend_q && bus_gnt_i) begin
      upd     = 1'b1;
      upd_idx = wb_idx_q;
      upd_st  = wb_next_q;
    end else if (snp_upd) begin
      upd     = 1'b1;
      upd_idx = snp_idx;
      upd_st  = snp_upd_st;
    end else begin
      case (fsm_q)
        F_IDLE: if (accept && cpu_hit && cpu_we_i && cpu_excl) begin
          upd = 1'b1; upd_st = ST_MOD; upd_fill = 1'b1;
        end
        F_UPG: if (fsm_gnt && cpu_hit) begin
          upd = 1'b1; upd_st = ST_MOD; upd_fill = 1'b1;
        end
        F_EVICT: if (fsm_gnt) begin
          upd = 1'b1; upd_st = ST_INV;
        end
        F_FILL: if (fsm_gnt && !bus_abort_i) begin
          upd      = 1'b1;
          upd_fill = 1'b1;
          upd_data = cpu_we_i ? cpu_wdata_i : bus_rdata_i;
          upd_st   = cpu_we_i ? ST_MOD : (bus_shared_i ? ST_SHD : ST_EXC);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q     <= F_IDLE;
      ready_q   <= 1'b0;
      rdata_q   <= '0;
      wb_pend_q <= 1'b0;
      wb_idx_q  <= '0;
      wb_addr_q <= '0;
      wb_data_q <= '0;
      wb_next_q <= ST_INV;
    end else begin
      fsm_q   <= fsm_d;
      ready_q <= ready_d;
      rdata_q <= rdata_d;
      if (wb_pend_q && bus_gnt_i) wb_pend_q <= 1'b0;
      else if (snp_abort_o && !wb_pend_q) begin
        wb_pend_q <= 1'b1;
        wb_idx_q  <= snp_idx;
        wb_addr_q <= snp_addr_i;
        wb_data_q <= sb_data;
        wb_next_q <= snp_wb_st;
      end
    end
  end

  assign cpu_ready_o = ready_q;
  assign cpu_rdata_o = rdata_q;

  // input assumptions
  assert_gnt_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i |-> bus_req_o);
  assert_no_snoop_on_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snp_valid_i && bus_gnt_i));

  assert_fill_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == F_FILL && fsm_gnt && !bus_abort_i && !cpu_we_i && !bus_shared_i)
    |=> ca_st == ST_EXC);
  assert_ready_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o);
  assert_excl_write_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == F_IDLE && accept && cpu_hit && cpu_we_i && cpu_excl)
    |=> cpu_ready_o && !bus_req_o);
  assert_inv_only_shared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == CMD_INV) |-> (cpu_hit && ca_st == ST_SHD));
  assert_abort_needs_copy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_abort_o |-> snp_shared_o);
  assert_wb_after_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_abort_o && !wb_pend_q)
    |=> bus_req_o && bus_cmd_o == CMD_WB && bus_addr_o == $past(snp_addr_i));
  assert_abort_retry_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == F_FILL && fsm_gnt && bus_abort_i) |=> (fsm_q == F_FILL && bus_req_o));
  assert_evict_then_fill_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == F_EVICT && fsm_gnt) |=> fsm_q == F_FILL);
endmodule

// File: tb/tb_mesi_cache_ctrl.sv
module tb_mesi_cache_ctrl;
  import mesi_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, gnt = 1'b0, abort_now = 1'b0;
  logic [2:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic tb_shared = 1'b0;
  logic snp_valid = 1'b0;
  logic [2:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_abort;

  logic [DW-1:0] mem [256];
  bit hold = 1'b0, abort_once = 1'b0;
  int total = 0, bad = 0;

  typedef struct packed {
    logic [2:0]    cmd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } xact_t;
  xact_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus_rdata = mem[bus_addr];

  mesi_cache_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_shared_i(tb_shared),
    .bus_abort_i(abort_now),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_abort_o(snp_abort)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void push(input logic [2:0] c, input logic [AW-1:0] a,
                               input logic [DW-1:0] d);
    exp_q.push_back('{cmd: c, addr: a, data: d});
  endfunction

  // arbiter, memory and bus monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      gnt <= 1'b0;
      abort_now <= 1'b0;
    end else if (gnt) begin
      gnt <= 1'b0;
      abort_now <= 1'b0;
    end else if (bus_req && !hold) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "bus", "unexpected command", {29'd0, bus_cmd}, 0);
      end else begin
        xact_t e;
        e = exp_q.pop_front();
        check(bus_cmd == e.cmd, "bus", "command", {29'd0, bus_cmd}, {29'd0, e.cmd});
        check(bus_addr == e.addr, "bus", "address", {24'd0, bus_addr}, {24'd0, e.addr});
        if (e.cmd == CMD_WB)
          check(bus_wdata == e.data, "bus", "wb data", {16'd0, bus_wdata}, {16'd0, e.data});
      end
      if (bus_cmd == CMD_WB) mem[bus_addr] = bus_wdata;
      if (abort_once && (bus_cmd == CMD_RD || bus_cmd == CMD_RWITM)) begin
        abort_now <= 1'b1;
        abort_once = 1'b0;
      end
      gnt <= 1'b1;
    end
  end

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] exp_rd, input string req, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready);
    if (!we) check(cpu_rdata == exp_rd, req, "read data", {16'd0, cpu_rdata}, {16'd0, exp_rd});
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic [2:0] c, input logic [AW-1:0] a,
                       input bit exp_sh, input bit exp_ab, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1;
    check(snp_shared == exp_sh, req, "snoop shared", {31'd0, snp_shared}, {31'd0, exp_sh});
    check(snp_abort == exp_ab, req, "snoop abort", {31'd0, snp_abort}, {31'd0, exp_ab});
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic drained(input string req);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, "missing bus commands", exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    for (int i = 0; i < 256; i++) mem[i] = DW'(16'h1000 + i * 7);
    repeat (3) @(negedge clk);
    check(cpu_ready == 1'b0, "R1", "ready in reset", {31'd0, cpu_ready}, 0);
    check(bus_req == 1'b0, "R1", "bus req in reset", {31'd0, bus_req}, 0);
    rst_n = 1'b1;
    snoop(CMD_RD, 8'h04, 1'b0, 1'b0, "R1");

    // R2: read miss, no peer copy -> Exclusive
    push(CMD_RD, 8'h04, '0);
    cpu_op(1'b0, 8'h04, '0, mem[8'h04], "R2", cyc);
    drained("R2");
    // R4: silent write on Exclusive
    cpu_op(1'b1, 8'h04, 16'hA0A0, '0, "R4", cyc);
    check(cyc == 1, "R4", "write hit latency", cyc, 1);
    drained("R4");
    // R3: read hit
    cpu_op(1'b0, 8'h04, '0, 16'hA0A0, "R3", cyc);
    check(cyc == 1, "R3", "read hit latency", cyc, 1);
    // R9: snooped read on Modified
    push(CMD_WB, 8'h04, 16'hA0A0);
    snoop(CMD_RD, 8'h04, 1'b1, 1'b1, "R9");
    drained("R9");
    check(mem[8'h04] == 16'hA0A0, "R9", "memory after wb", {16'd0, mem[8'h04]}, 32'hA0A0);
    // now Shared: write upgrades with INV (R5)
    push(CMD_INV, 8'h04, '0);
    cpu_op(1'b1, 8'h04, 16'hB1B1, '0, "R5", cyc);
    drained("R5");
    // R9: snooped RWITM on Modified -> wb then Invalid
    push(CMD_WB, 8'h04, 16'hB1B1);
    snoop(CMD_RWITM, 8'h04, 1'b1, 1'b1, "R9");
    drained("R9");
    snoop(CMD_RD, 8'h04, 1'b0, 1'b0, "R9");

    // R2: fill with peer copy -> Shared; R8 snooped read keeps Shared
    tb_shared = 1'b1;
    push(CMD_RD, 8'h05, '0);
    cpu_op(1'b0, 8'h05, '0, mem[8'h05], "R2", cyc);
    tb_shared = 1'b0;
    snoop(CMD_RD, 8'h05, 1'b1, 1'b0, "R8");
    push(CMD_INV, 8'h05, '0);
    cpu_op(1'b1, 8'h05, 16'hC2C2, '0, "R8", cyc);
    drained("R8");

    // R8: snooped read moves Exclusive to Shared; R7 shared flag
    push(CMD_RD, 8'h06, '0);
    cpu_op(1'b0, 8'h06, '0, mem[8'h06], "R2", cyc);
    snoop(CMD_RD, 8'h06, 1'b1, 1'b0, "R7");
    push(CMD_INV, 8'h06, '0);
    cpu_op(1'b1, 8'h06, 16'hD3D3, '0, "R8", cyc);
    drained("R8");

    // R10: INV on Shared, RWITM on Exclusive
    tb_shared = 1'b1;
    push(CMD_RD, 8'h07, '0);
    cpu_op(1'b0, 8'h07, '0, mem[8'h07], "R10", cyc);
    tb_shared = 1'b0;
    snoop(CMD_INV, 8'h07, 1'b1, 1'b0, "R10");
    snoop(CMD_RD, 8'h07, 1'b0, 1'b0, "R10");
    push(CMD_RD, 8'h07, '0);
    cpu_op(1'b0, 8'h07, '0, mem[8'h07], "R10", cyc);
    drained("R10");
    push(CMD_RD, 8'h08, '0);
    cpu_op(1'b0, 8'h08, '0, mem[8'h08], "R10", cyc);
    snoop(CMD_RWITM, 8'h08, 1'b1, 1'b0, "R10");
    snoop(CMD_RD, 8'h08, 1'b0, 1'b0, "R10");
    drained("R10");

    // R6: write miss
    push(CMD_RWITM, 8'h0C, '0);
    cpu_op(1'b1, 8'h0C, 16'hE4E4, '0, "R6", cyc);
    cpu_op(1'b0, 8'h0C, '0, 16'hE4E4, "R6", cyc);
    check(cyc == 1, "R6", "hit after write miss", cyc, 1);
    drained("R6");

    // R13: dirty victim written back first, clean victim dropped
    push(CMD_WB, 8'h0C, 16'hE4E4);
    push(CMD_RD, 8'h10, '0);
    cpu_op(1'b0, 8'h10, '0, mem[8'h10], "R13", cyc);
    drained("R13");
    push(CMD_RD, 8'h14, '0);
    cpu_op(1'b0, 8'h14, '0, mem[8'h14], "R13", cyc);
    drained("R13");
    push(CMD_RD, 8'h0C, '0);
    cpu_op(1'b0, 8'h0C, '0, 16'hE4E4, "R13", cyc);
    drained("R13");

    // R12: aborted fill is retried
    abort_once = 1'b1;
    push(CMD_WB, 8'h05, 16'hC2C2);
    push(CMD_RD, 8'h21, '0);
    push(CMD_RD, 8'h21, '0);
    cpu_op(1'b0, 8'h21, '0, mem[8'h21], "R12", cyc);
    drained("R12");

    // R11: upgrade loses race, reissued as RWITM
    tb_shared = 1'b1;
    push(CMD_WB, 8'h06, 16'hD3D3);
    push(CMD_RD, 8'h0A, '0);
    cpu_op(1'b0, 8'h0A, '0, mem[8'h0A], "R11", cyc);
    tb_shared = 1'b0;
    drained("R11");
    hold = 1'b1;
    push(CMD_RWITM, 8'h0A, '0);
    fork
      begin
        int c2;
        cpu_op(1'b1, 8'h0A, 16'hF5F5, '0, "R11", c2);
      end
    join_none
    repeat (3) @(negedge clk);
    snoop(CMD_INV, 8'h0A, 1'b1, 1'b0, "R11");
    hold = 1'b0;
    wait fork;
    drained("R11");
    cpu_op(1'b0, 8'h0A, '0, 16'hF5F5, "R11", cyc);
    check(cyc == 1, "R11", "hit after reissue", cyc, 1);

    // R14: snoop writeback overtakes a waiting fill
    hold = 1'b1;
    push(CMD_WB, 8'h0A, 16'hF5F5);
    push(CMD_RD, 8'h0B, '0);
    fork
      begin
        int c3;
        cpu_op(1'b0, 8'h0B, '0, mem[8'h0B], "R14", c3);
      end
    join_none
    repeat (3) @(negedge clk);
    snoop(CMD_RD, 8'h0A, 1'b1, 1'b1, "R14");
    hold = 1'b0;
    wait fork;
    drained("R14");
    // line downgraded to Shared by the snooped read (R9)
    push(CMD_INV, 8'h0A, '0);
    cpu_op(1'b1, 8'h0A, 16'h0606, '0, "R9", cyc);
    drained("R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule